// File: doc/BRIEF.md
# Serial DAC Frame Writer

This block is the host side of a three-wire write link to a 16-bit voltage-output converter. A client hands it a 16-bit code and a 2-bit power mode on a valid/ready handshake. The block packs them into a 24-bit word: six zero bits, then the two mode bits, then the code. It shifts the word out most significant bit first. The active-low frame strobe stays low for the whole word.

The serial clock comes from the system clock. Each half period lasts a parameter number of system clocks. The clock idles low. Data changes on the rising edge and the receiver samples it on the falling edge. The word goes out as three bytes back to back, with an optional extra low time after the eighth and sixteenth bits, as an 8-bit host would produce. After the word the strobe stays high for a parameter number of clocks before the next request is accepted.

The block remembers whether the last write put the converter into power-down (any non-zero mode). A mode-00 write that wakes the converter keeps ready low for a further wake window. For sources that deliver each code byte least significant bit first, an elaboration option mirrors each code byte before it is sent.

Top module: `dac_frame_writer`

## Requirements
- R1: After a synchronous reset the outputs are `sync_n`=1, `sclk`=0, `sdo`=0 and `in_ready`=1.
- R2: The 24 bits sampled at the falling `sclk` edges while `sync_n` is low are, in order: six 0 bits, `in_mode[1]`, `in_mode[0]`, then `in_code[15]` down to `in_code[0]`. Exactly 24 falling edges occur per frame.
- R3: With `LSB_FIRST_IN`=1 the code part is sent as `in_code[8]`..`in_code[15]` and then `in_code[0]`..`in_code[7]`. The zero bits and the mode bits are unchanged.
- R4: `sclk` is never high while `sync_n` is high. `sdo` is 0 while `sync_n` is high. Inside a frame, `sdo` changes only in the cycle where `sclk` rises.
- R5: `sync_n` falls one cycle after a handshake is accepted. `sclk` first rises DIV_HALF clocks later. Every high phase lasts DIV_HALF clocks. Every low phase lasts DIV_HALF clocks, except the low phase after the 8th and 16th falling edges, which lasts DIV_HALF+BYTE_PAUSE clocks. `sync_n` rises DIV_HALF clocks after the 24th falling edge.
- R6: After it rises, `sync_n` stays high for at least GAP_CLKS clocks. `in_ready` is low for exactly 49·DIV_HALF+2·BYTE_PAUSE+GAP_CLKS clocks after an acceptance, unless R8 applies.
- R7: A request raised while `in_ready` is low waits, with no frame started. It is accepted on the first cycle `in_ready` returns high. Every accepted request yields exactly one complete frame.
- R8: A non-zero mode marks the converter powered down. A mode-00 write accepted while it is marked powered down keeps `in_ready` low for WAKE_CLKS further clocks. No other write gets this extension.
- R9: A reset during a frame returns the outputs to the R1 state on the next cycle and clears the power-down mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Write request |
| in_ready | output | 1 | Request accepted on a cycle where both are high |
| in_code | input | 16 | Converter code |
| in_mode | input | 2 | Power mode, 00 = normal, other values = power-down |
| sclk | output | 1 | Serial clock, idles low |
| sync_n | output | 1 | Active-low frame strobe |
| sdo | output | 1 | Serial data, stable at falling `sclk` |

## Verification
The wake extension is the hardest case to reach from the ports. It needs a power-down write followed by a mode-00 write, and it must be told apart from repeated power-down writes and normal writes. The stimulus therefore mixes random modes with a directed sequence: power-down, power-down again, wake, then normal.

A reset in mid-frame is driven while the strobe is low. The next mode-00 write then checks that the power-down mark was cleared. A request held valid throughout a busy period checks that it is accepted without loss.

// File: rtl/dac_frame_writer.sv
module dac_frame_writer #(
  parameter int DIV_HALF     = 2,
  parameter int BYTE_PAUSE   = 0,
  parameter int GAP_CLKS     = 2,
  parameter int WAKE_CLKS    = 100,
  parameter bit LSB_FIRST_IN = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_code,
  input  logic [1:0]  in_mode,
  output logic        sclk,
  output logic        sync_n,
  output logic        sdo
);
  localparam int LONG_HALF = DIV_HALF + BYTE_PAUSE;
  localparam int CMAX = (LONG_HALF > GAP_CLKS)
                      ? ((LONG_HALF > WAKE_CLKS) ? LONG_HALF : WAKE_CLKS)
                      : ((GAP_CLKS > WAKE_CLKS) ? GAP_CLKS : WAKE_CLKS);
  localparam int CW = $clog2(CMAX + 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(DIV_HALF - 1);
  localparam logic [CW-1:0] LONG_M1 = CW'(LONG_HALF - 1);
  localparam logic [CW-1:0] GAP_M1  = CW'(GAP_CLKS - 1);
  localparam logic [CW-1:0] WAKE_M1 = CW'(WAKE_CLKS - 1);
  localparam logic [5:0]    LAST_PH = 6'd48;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_GAP, S_WAKE} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [5:0]   ph;
  logic [23:0]  shreg;
  logic         sclk_q, sync_q, sdo_q;
  logic         asleep, wake_due;
  logic [15:0]  code_fix;

  generate
    if (LSB_FIRST_IN) begin : g_mirror
      for (genvar i = 0; i < 8; i++) begin : g_bit
        assign code_fix[i]     = in_code[7 - i];
        assign code_fix[8 + i] = in_code[15 - i];
      end
    end else begin : g_direct
      assign code_fix = in_code;
    end
  endgenerate

  assign in_ready = (st == S_IDLE);
  assign sclk     = sclk_q;
  assign sync_n   = sync_q;
  assign sdo      = sdo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ph       <= '0;
      shreg    <= '0;
      sclk_q   <= 1'b0;
      sync_q   <= 1'b1;
      sdo_q    <= 1'b0;
      asleep   <= 1'b0;
      wake_due <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (in_valid) begin
            shreg    <= {6'b0, in_mode, code_fix};
            sync_q   <= 1'b0;
            sclk_q   <= 1'b0;
            sdo_q    <= 1'b0;
            ph       <= '0;
            cnt      <= HALF_M1;
            wake_due <= asleep && (in_mode == 2'b00);
            asleep   <= (in_mode != 2'b00);
            st       <= S_SEND;
          end
        end
        S_SEND: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (ph == LAST_PH) begin
            sync_q <= 1'b1;
            sdo_q  <= 1'b0;
            cnt    <= GAP_M1;
            st     <= S_GAP;
          end else begin
            ph <= ph + 1'b1;
            if (!ph[0]) begin
              sclk_q <= 1'b1;
              sdo_q  <= shreg[23];
              shreg  <= {shreg[22:0], 1'b0};
              cnt    <= HALF_M1;
            end else begin
              sclk_q <= 1'b0;
              cnt    <= (ph == 6'd15 || ph == 6'd31) ? LONG_M1 : HALF_M1;
            end
          end
        end
        S_GAP: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (wake_due) begin
            wake_due <= 1'b0;
            cnt      <= WAKE_M1;
            st       <= S_WAKE;
          end else begin
            st <= S_IDLE;
          end
        end
        S_WAKE: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else           st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_frame_writer_chk.sv
module dac_frame_writer_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic sclk,
  input logic sync_n,
  input logic sdo
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (sync_n && !sclk && !sdo && in_ready));

  assert_clock_inside_frame_R4: assert property (@(posedge clk) disable iff (rst)
    sync_n |-> (!sclk && !sdo));

  assert_data_moves_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (!sync_n && !$rose(sclk)) |-> $stable(sdo));

  assert_frame_follows_accept_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !sync_n);

  assert_busy_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
    !sync_n |-> !in_ready);

  assert_gap_holds_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |=> sync_n);
endmodule

bind dac_frame_writer dac_frame_writer_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .sclk(sclk), .sync_n(sync_n), .sdo(sdo)
);

// File: tb/dac_frame_writer_bench.sv
module dac_frame_writer_bench;
  localparam int CLK_NS = 10;
  localparam int D = 3;
  localparam int P = 2;
  localparam int G = 4;
  localparam int W = 20;
  localparam int BASE_L = 49 * D + 2 * P + G;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] in_code = '0;
  logic [1:0]  in_mode = '0;
  logic rdy [2];
  logic sck [2];
  logic syn [2];
  logic dout [2];

  always #(CLK_NS / 2) clk = ~clk;

  dac_frame_writer #(.DIV_HALF(D), .BYTE_PAUSE(P), .GAP_CLKS(G), .WAKE_CLKS(W),
                     .LSB_FIRST_IN(1'b0)) u_dac_frame_writer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy[0]),
    .in_code(in_code), .in_mode(in_mode), .sclk(sck[0]), .sync_n(syn[0]), .sdo(dout[0]));

  dac_frame_writer #(.DIV_HALF(D), .BYTE_PAUSE(P), .GAP_CLKS(G), .WAKE_CLKS(W),
                     .LSB_FIRST_IN(1'b1)) u_dac_frame_writer_rev (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy[1]),
    .in_code(in_code), .in_mode(in_mode), .sclk(sck[1]), .sync_n(syn[1]), .sdo(dout[1]));

  int total = 0;
  int bad = 0;
  int done_exp = 0;
  int frames [2];
  logic [23:0] expf [2];
  bit pd_model = 1'b0;
  bit wake_exp = 1'b0;
  int exp_len = BASE_L;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7 - i];
  endfunction

  function automatic logic [23:0] mk_frame(input logic [15:0] c, input logic [1:0] m, input bit mir);
    logic [15:0] cf;
    cf = mir ? {rev8(c[15:8]), rev8(c[7:0])} : c;
    return {6'b0, m, cf};
  endfunction

  // serial monitor for both instances
  logic psck [2];
  logic psyn [2];
  logic pdout [2];
  bit   inframe [2];
  int   run [2];
  int   nfall [2];
  int   gapc [2];
  logic [23:0] bits [2];

  initial begin
    for (int i = 0; i < 2; i++) frames[i] = 0;
  end

  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        psck[i] = 1'b0; psyn[i] = 1'b1; pdout[i] = 1'b0;
        inframe[i] = 1'b0; run[i] = 0; nfall[i] = 0; gapc[i] = G; bits[i] = '0;
      end else begin
        if (rdy[i] != rdy[0]) chk(1'b0, "R3 ready mismatch", rdy[i], rdy[0]);
        if (syn[i] && (sck[i] || dout[i])) chk(1'b0, "R4 idle lines", {sck[i], dout[i]}, 0);
        if (psyn[i] && !syn[i]) begin
          chk(gapc[i] >= G, "R6 sync high gap", gapc[i], G);
          inframe[i] = 1'b1; nfall[i] = 0; run[i] = 1; bits[i] = '0;
        end else if (!syn[i] && inframe[i]) begin
          if (dout[i] != pdout[i] && !(sck[i] && !psck[i]))
            chk(1'b0, "R4 data change off rise", dout[i], pdout[i]);
          if (sck[i] && !psck[i]) begin
            int el;
            el = (nfall[i] == 8 || nfall[i] == 16) ? D + P : D;
            chk(run[i] == el, "R5 low phase", run[i], el);
            run[i] = 1;
          end else if (!sck[i] && psck[i]) begin
            chk(run[i] == D, "R5 high phase", run[i], D);
            bits[i] = {bits[i][22:0], dout[i]};
            nfall[i]++;
            run[i] = 1;
          end else begin
            run[i]++;
          end
        end else if (!psyn[i] && syn[i] && inframe[i]) begin
          chk(run[i] == D, "R5 tail before sync rise", run[i], D);
          chk(nfall[i] == 24, "R2 falling edge count", nfall[i], 24);
          chk(bits[i] == expf[i], (i == 0) ? "R2 frame bits" : "R3 mirrored bits", bits[i], expf[i]);
          inframe[i] = 1'b0; gapc[i] = 1; frames[i]++;
        end else if (syn[i]) begin
          gapc[i]++;
        end
        psck[i] = sck[i]; psyn[i] = syn[i]; pdout[i] = dout[i];
      end
    end
  end

  task automatic accept(input logic [15:0] c, input logic [1:0] m);
    in_code = c; in_mode = m; in_valid = 1'b1;
    while (!rdy[0]) @(negedge clk);
    expf[0] = mk_frame(c, m, 1'b0);
    expf[1] = mk_frame(c, m, 1'b1);
    wake_exp = pd_model && (m == 2'b00);
    pd_model = (m != 2'b00);
    exp_len = BASE_L + (wake_exp ? W : 0);
    done_exp++;
    @(negedge clk);
    chk(!syn[0], "R5 sync falls after accept", syn[0], 0);
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (!rdy[0] && n < 100000) begin
      n++;
      @(negedge clk);
    end
    chk(n == exp_len, wake_exp ? "R8 busy with wake" : "R6 busy length", n, exp_len);
  endtask

  task automatic send(input logic [15:0] c, input logic [1:0] m);
    accept(c, m);
    in_valid = 1'b0;
    drain();
  endtask

  initial begin
    void'($urandom(32'd914));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(syn[0] && !sck[0] && !dout[0] && rdy[0], "R1 reset state",
        {syn[0], sck[0], dout[0], rdy[0]}, 4'b1001);

    send(16'h0000, 2'b00);
    send(16'hFFFF, 2'b00);
    send(16'h8001, 2'b00);
    send(16'hA5C3, 2'b00);

    send(16'h1234, 2'b01);   // enter power-down, no wake
    send(16'h1234, 2'b10);   // still down, no wake  (R8)
    send(16'h5555, 2'b00);   // wake window R8
    send(16'h5555, 2'b00);   // normal, no wake

    // R7: request held while busy
    accept(16'h0F0F, 2'b11);
    in_code = 16'hC33C; in_mode = 2'b00;
    drain();
    accept(16'hC33C, 2'b00);
    in_valid = 1'b0;
    drain();

    // R9: reset mid-frame after a power-down write
    accept(16'h7777, 2'b01);
    in_valid = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(syn[0] && !sck[0] && !dout[0] && rdy[0], "R9 reset mid-frame",
        {syn[0], sck[0], dout[0], rdy[0]}, 4'b1001);
    rst = 1'b0;
    done_exp--;
    pd_model = 1'b0;
    for (int i = 0; i < 2; i++) frames[i] = frames[i];
    @(negedge clk);
    send(16'h2222, 2'b00);   // R9: no wake after reset

    for (int k = 0; k < 40; k++) begin
      logic [15:0] c;
      logic [1:0]  m;
      c = 16'($urandom);
      m = ($urandom_range(0, 1) == 0) ? 2'b00 : 2'($urandom_range(1, 3));
      send(c, m);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    repeat (5) @(negedge clk);
    chk(frames[0] == done_exp, "R7 frames completed", frames[0], done_exp);
    chk(frames[1] == done_exp, "R7 mirrored frames completed", frames[1], done_exp);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule